// File: doc/BRIEF.md
# Power-on Strap Sampler and Serial EEPROM Configuration Loader

This block runs once the chip leaves reset. It first keeps all four serial EEPROM pins undriven and reads their pulled levels as straps. A strap decides whether an EEPROM is fitted. If it is, the block acts as a four-wire serial master and reads the configuration words. It checks the first word against a signature. Only when that word matches does it copy the remaining words into the configuration registers.

Once boot ends, the block releases every pin and listens to the bus. A host processor may later reprogram the EEPROM over the same wires. Whenever the host sends a well-formed WRITE in its own chip-select pulse, the matching configuration register takes the new data, so the registers track the EEPROM. The host may also write the registers directly through a parallel port, but only once a long settling window after reset has passed.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is low, and until LOAD_DLY cycles after reset release, the output enables of CS, SK and DI are all low.
- R2: The four straps show the defaults before they are latched: EEPROM enable 1, dual colour 0, auto-MDIX 0, CS level 0. STRAP_DLY cycles after reset release they take the pin levels (DO gives the EEPROM enable, DI gives dual colour, SK gives auto-MDIX, CS gives the CS level). Later pin changes do not alter them.
- R3: With the EEPROM-enable strap low, no pin is driven, boot_done rises shortly after LOAD_DLY and stays high, and every configuration register stays zero.
- R4: Each read frame has 25 SK pulses: start bit 1, opcode 10, a 6-bit word address MSB first, then 16 data bits MSB first. DI is stable while SK is high. DO is sampled on each SK rising edge. Each SK high phase lasts SK_HALF clock cycles.
- R5: Words are read in order, from address 0 to NUM_REGS. Each word uses its own CS-high pulse, and SK is only high while CS is high.
- R6: If word 0 differs from SIG_VALUE, reading stops after word 0, boot_done rises and all registers stay zero.
- R7: If word 0 equals SIG_VALUE, register k-1 holds EEPROM word k for k from 1 to NUM_REGS.
- R8: Once boot_done is high, none of the pin output enables is high.
- R9: After boot, an observed CS pulse that carries exactly 25 SK rising edges, with start 1, opcode 01, address A (1 to NUM_REGS) and 16 data bits MSB first, loads those data bits into register A-1.
- R10: Any other observed pulse changes no register. This covers another opcode, address 0 or an address above NUM_REGS, and a bit count other than 25, as when a 9-bit write-enable instruction shares the pulse with a WRITE.
- R11: A direct write (reg_wr_en, index reg_wr_addr, data reg_wr_data) is ignored before CPU_OK_DLY cycles after reset release and whenever the index is NUM_REGS or more. Otherwise the register takes the data on the next edge.
- R12: If a snooped WRITE and a direct write target the same register in the same cycle, the snooped data wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ee_cs_i | input | 1 | CS pin level |
| ee_cs_o | output | 1 | CS drive value |
| ee_cs_oe | output | 1 | CS output enable |
| ee_sk_i | input | 1 | SK pin level |
| ee_sk_o | output | 1 | SK drive value |
| ee_sk_oe | output | 1 | SK output enable |
| ee_di_i | input | 1 | DI pin level |
| ee_di_o | output | 1 | DI drive value |
| ee_di_oe | output | 1 | DI output enable |
| ee_do_i | input | 1 | DO pin level (EEPROM data out) |
| strap_eeprom_en | output | 1 | Latched EEPROM-enable strap |
| strap_dual_color | output | 1 | Latched dual-colour LED strap |
| strap_auto_mdix | output | 1 | Latched auto-MDIX strap |
| strap_cs_level | output | 1 | Latched CS strap level |
| reg_wr_en | input | 1 | Direct register write strobe |
| reg_wr_addr | input | 6 | Direct write register index |
| reg_wr_data | input | 16 | Direct write data |
| cfg_regs | output | NUM_REGS*16 | Configuration registers, register i in bits [16i+15:16i] |
| boot_done | output | 1 | Boot load finished or skipped |

## Verification
The boot path is exercised in three reset scenarios: a valid signature with random contents, a corrupted signature, and the EEPROM strap pulled low. These separate copying, aborting and skipping. An EEPROM model checks every frame's command bits, addresses and SK timing. After boot, random host frames mix valid WRITEs with wrong-opcode, out-of-range, over-long (write-enable plus WRITE) and truncated frames. The bench keeps a reference register image for these, so a decoder that accepts a bad frame, or drops a good one, shows up. Direct writes are tried inside and outside the settling window and against a snooped WRITE to the same register in the same cycle.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
  localparam int ADDR_W     = 6;
  localparam int WORD_W     = 16;
  localparam int CMD_BITS   = 9;
  localparam int FRAME_BITS = 25;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [2:0] {
    MW_IDLE, MW_LOW, MW_HIGH, MW_GAP, MW_DONE
  } mw_state_e;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] idx;
    logic [WORD_W-1:0] data;
  } cfg_wr_t;
endpackage

// File: rtl/cfg_boot_timer.sv
module cfg_boot_timer #(
  parameter int STRAP_DLY  = 40,
  parameter int LOAD_DLY   = 160,
  parameter int CPU_OK_DLY = 6000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s,
  output logic strap_pulse,
  output logic load_start,
  output logic cpu_open
);
  localparam int LIMIT = (CPU_OK_DLY > LOAD_DLY) ? CPU_OK_DLY : LOAD_DLY;
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  // reset release synchronised to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s = sync_q[1];

  always_comb begin
    cnt_nx = cnt_q;
    if (rst_s && (cnt_q != CNT_W'(LIMIT))) cnt_nx = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign strap_pulse = rst_s && (cnt_q == CNT_W'(STRAP_DLY));
  assign load_start  = rst_s && (cnt_q >= CNT_W'(LOAD_DLY));
  assign cpu_open    = rst_s && (cnt_q >= CNT_W'(CPU_OK_DLY));
endmodule

// File: rtl/cfg_mw_master.sv
module cfg_mw_master
  import cfg_boot_pkg::*;
#(
  parameter int          NUM_WORDS = 8,
  parameter int          SK_HALF   = 100,
  parameter logic [15:0] SIG_VALUE = 16'h4154
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    do_i,
  output logic    cs_o,
  output logic    sk_o,
  output logic    di_o,
  output logic    drive,
  output logic    done,
  output cfg_wr_t wr
);
  localparam int DIV_W = $clog2(SK_HALF + 1);
  localparam logic [4:0] LAST_BIT = 5'(FRAME_BITS - 1);

  mw_state_e         st_q, st_nx;
  logic [DIV_W-1:0]  div_q, div_nx;
  logic [4:0]        bit_q, bit_nx;
  logic [ADDR_W-1:0] word_q, word_nx;
  logic [WORD_W-1:0] sh_q, sh_nx;
  logic              fin_q, fin_nx;
  logic              tick, active, last_word;
  logic [FRAME_BITS-1:0] frame;

  assign active    = (st_q == MW_LOW) || (st_q == MW_HIGH) || (st_q == MW_GAP);
  assign tick      = active && (div_q == DIV_W'(SK_HALF - 1));
  assign last_word = (word_q == ADDR_W'(NUM_WORDS));
  assign frame     = {1'b1, OP_READ, word_q, {WORD_W{1'b0}}};

  always_comb begin
    div_nx = (!active || tick) ? '0 : div_q + DIV_W'(1);
  end

  always_comb begin
    st_nx   = st_q;
    bit_nx  = bit_q;
    word_nx = word_q;
    sh_nx   = sh_q;
    fin_nx  = fin_q;
    unique case (st_q)
      MW_IDLE: if (start) begin
        st_nx   = MW_LOW;
        bit_nx  = '0;
        word_nx = '0;
      end
      MW_LOW: if (tick) begin
        st_nx = MW_HIGH;
        if (bit_q >= 5'(CMD_BITS)) sh_nx = {sh_q[WORD_W-2:0], do_i};
      end
      MW_HIGH: if (tick) begin
        if (bit_q == LAST_BIT) begin
          st_nx  = MW_GAP;
          fin_nx = last_word || ((word_q == '0) && (sh_q != SIG_VALUE));
        end else begin
          st_nx  = MW_LOW;
          bit_nx = bit_q + 5'd1;
        end
      end
      MW_GAP: if (tick) begin
        if (fin_q) st_nx = MW_DONE;
        else begin
          st_nx   = MW_LOW;
          bit_nx  = '0;
          word_nx = word_q + ADDR_W'(1);
        end
      end
      MW_DONE: st_nx = MW_DONE;
      default: st_nx = MW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MW_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      word_q <= '0;
      sh_q   <= '0;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_nx;
      div_q  <= div_nx;
      bit_q  <= bit_nx;
      word_q <= word_nx;
      sh_q   <= sh_nx;
      fin_q  <= fin_nx;
    end
  end

  assign cs_o  = (st_q == MW_LOW) || (st_q == MW_HIGH);
  assign sk_o  = (st_q == MW_HIGH);
  assign di_o  = cs_o ? frame[LAST_BIT - bit_q] : 1'b0;
  assign drive = active;
  assign done  = (st_q == MW_DONE);

  always_comb begin
    wr.we   = (st_q == MW_HIGH) && tick && (bit_q == LAST_BIT) && (word_q != '0);
    wr.idx  = word_q - ADDR_W'(1);
    wr.data = sh_q;
  end
endmodule

// File: rtl/cfg_mw_snoop.sv
module cfg_mw_snoop
  import cfg_boot_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    cs_i,
  input  logic    sk_i,
  input  logic    di_i,
  output cfg_wr_t wr
);
  localparam logic [5:0] CNT_MAX = 6'h3f;

  // bit order {cs, sk, di}
  logic [2:0]            s1_q, s2_q, pv_q;
  logic [5:0]            cnt_q, cnt_nx;
  logic [FRAME_BITS-1:0] sh_q, sh_nx;
  logic                  cs_rise, cs_fall, sk_rise;
  logic [ADDR_W-1:0]     addr;

  assign cs_rise = s2_q[2] && !pv_q[2];
  assign cs_fall = !s2_q[2] && pv_q[2];
  assign sk_rise = s2_q[1] && !pv_q[1];
  assign addr    = sh_q[WORD_W +: ADDR_W];

  always_comb begin
    cnt_nx = cnt_q;
    sh_nx  = sh_q;
    if (cs_rise) begin
      cnt_nx = '0;
      sh_nx  = '0;
    end else if (s2_q[2] && sk_rise && (cnt_q != CNT_MAX)) begin
      cnt_nx = cnt_q + 6'd1;
      sh_nx  = {sh_q[FRAME_BITS-2:0], s2_q[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      pv_q  <= '0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      s1_q  <= {cs_i, sk_i, di_i};
      s2_q  <= s1_q;
      pv_q  <= s2_q;
      cnt_q <= cnt_nx;
      sh_q  <= sh_nx;
    end
  end

  always_comb begin
    wr.we   = enable && cs_fall && (cnt_q == 6'(FRAME_BITS)) &&
              sh_q[FRAME_BITS-1] && (sh_q[FRAME_BITS-2 -: 2] == OP_WRITE) &&
              (addr != '0) && (addr <= ADDR_W'(NUM_REGS));
    wr.idx  = addr - ADDR_W'(1);
    wr.data = sh_q[WORD_W-1:0];
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_boot_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  cfg_wr_t                    ld_wr,
  input  cfg_wr_t                    sn_wr,
  input  cfg_wr_t                    cpu_wr,
  output logic [NUM_REGS*WORD_W-1:0] regs
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [WORD_W-1:0] q, nx;
    // priority: boot loader, then snooped write, then direct write
    always_comb begin
      nx = q;
      if (ld_wr.we && (ld_wr.idx == ADDR_W'(i)))        nx = ld_wr.data;
      else if (sn_wr.we && (sn_wr.idx == ADDR_W'(i)))   nx = sn_wr.data;
      else if (cpu_wr.we && (cpu_wr.idx == ADDR_W'(i))) nx = cpu_wr.data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nx;
    end
    assign regs[i*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader
  import cfg_boot_pkg::*;
#(
  parameter int          NUM_REGS   = 8,
  parameter int          SK_HALF    = 100,
  parameter int          STRAP_DLY  = 40,
  parameter int          LOAD_DLY   = 160,
  parameter int          CPU_OK_DLY = 6000000,
  parameter logic [15:0] SIG_VALUE  = 16'h4154
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ee_cs_i,
  output logic                       ee_cs_o,
  output logic                       ee_cs_oe,
  input  logic                       ee_sk_i,
  output logic                       ee_sk_o,
  output logic                       ee_sk_oe,
  input  logic                       ee_di_i,
  output logic                       ee_di_o,
  output logic                       ee_di_oe,
  input  logic                       ee_do_i,
  output logic                       strap_eeprom_en,
  output logic                       strap_dual_color,
  output logic                       strap_auto_mdix,
  output logic                       strap_cs_level,
  input  logic                       reg_wr_en,
  input  logic [5:0]                 reg_wr_addr,
  input  logic [15:0]                reg_wr_data,
  output logic [NUM_REGS*16-1:0]     cfg_regs,
  output logic                       boot_done
);
  // strap order {eeprom_en, dual_color, auto_mdix, cs_level}
  localparam logic [3:0] STRAP_RST = 4'b1000;

  logic       rst_s, strap_pulse, load_start, cpu_open;
  logic [3:0] strap_q, strap_nx;
  logic       done_q, done_nx;
  logic       m_drive, m_done, m_cs, m_sk, m_di;
  cfg_wr_t    ld_wr, sn_wr, cpu_wr;

  cfg_boot_timer #(
    .STRAP_DLY (STRAP_DLY),
    .LOAD_DLY  (LOAD_DLY),
    .CPU_OK_DLY(CPU_OK_DLY)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_s      (rst_s),
    .strap_pulse(strap_pulse),
    .load_start (load_start),
    .cpu_open   (cpu_open)
  );

  always_comb begin
    strap_nx = strap_q;
    if (strap_pulse) strap_nx = {ee_do_i, ee_di_i, ee_sk_i, ee_cs_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strap_q <= STRAP_RST;
    else        strap_q <= strap_nx;
  end

  assign strap_eeprom_en  = strap_q[3];
  assign strap_dual_color = strap_q[2];
  assign strap_auto_mdix  = strap_q[1];
  assign strap_cs_level   = strap_q[0];

  cfg_mw_master #(
    .NUM_WORDS(NUM_REGS),
    .SK_HALF  (SK_HALF),
    .SIG_VALUE(SIG_VALUE)
  ) u_master (
    .clk  (clk),
    .rst_n(rst_n),
    .start(load_start && strap_q[3] && rst_s),
    .do_i (ee_do_i),
    .cs_o (m_cs),
    .sk_o (m_sk),
    .di_o (m_di),
    .drive(m_drive),
    .done (m_done),
    .wr   (ld_wr)
  );

  always_comb begin
    done_nx = done_q || m_done || (load_start && !strap_q[3]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_nx;
  end
  assign boot_done = done_q;

  assign ee_cs_o  = m_cs;
  assign ee_sk_o  = m_sk;
  assign ee_di_o  = m_di;
  assign ee_cs_oe = m_drive;
  assign ee_sk_oe = m_drive;
  assign ee_di_oe = m_drive;

  cfg_mw_snoop #(
    .NUM_REGS(NUM_REGS)
  ) u_snoop (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(done_q),
    .cs_i  (ee_cs_i),
    .sk_i  (ee_sk_i),
    .di_i  (ee_di_i),
    .wr    (sn_wr)
  );

  always_comb begin
    cpu_wr.we   = reg_wr_en && cpu_open && (reg_wr_addr < ADDR_W'(NUM_REGS));
    cpu_wr.idx  = reg_wr_addr;
    cpu_wr.data = reg_wr_data;
  end

  cfg_regfile #(
    .NUM_REGS(NUM_REGS)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_wr (ld_wr),
    .sn_wr (sn_wr),
    .cpu_wr(cpu_wr),
    .regs  (cfg_regs)
  );
endmodule

// File: rtl/cfg_boot_loader_chk.sv
module cfg_boot_loader_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ee_cs_o,
  input logic                   ee_cs_oe,
  input logic                   ee_sk_o,
  input logic                   ee_sk_oe,
  input logic                   ee_di_o,
  input logic                   ee_di_oe,
  input logic                   strap_eeprom_en,
  input logic                   boot_done,
  input logic                   any_we,
  input logic [NUM_REGS*16-1:0] cfg_regs
);
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done); // R3

  AST_NO_DRIVE_NO_EEPROM: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_eeprom_en |-> !(ee_cs_oe || ee_sk_oe || ee_di_oe)); // R3

  AST_PINS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !(ee_cs_oe || ee_sk_oe || ee_di_oe)); // R8

  AST_DI_HELD_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk_oe && ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o)); // R4

  AST_SK_ONLY_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk_oe && ee_sk_o) |-> ee_cs_o); // R5

  AST_REGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !any_we |=> $stable(cfg_regs)); // R10
endmodule

bind cfg_boot_loader cfg_boot_loader_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ee_cs_o        (ee_cs_o),
  .ee_cs_oe       (ee_cs_oe),
  .ee_sk_o        (ee_sk_o),
  .ee_sk_oe       (ee_sk_oe),
  .ee_di_o        (ee_di_o),
  .ee_di_oe       (ee_di_oe),
  .strap_eeprom_en(strap_eeprom_en),
  .boot_done      (boot_done),
  .any_we         (ld_wr.we | sn_wr.we | cpu_wr.we),
  .cfg_regs       (cfg_regs)
);

// File: tb/cfg_boot_loader_tb.sv
`timescale 1ns/1ps
module cfg_boot_loader_tb;
  localparam int          NR     = 4;
  localparam int          SKH    = 3;
  localparam int          SDLY   = 40;
  localparam int          LDLY   = 160;
  localparam int          CDLY   = 3000;
  localparam logic [15:0] SIG    = 16'h4154;
  localparam int          HHALF  = 4;

  logic clk, rst_n;
  logic ee_cs_i, ee_cs_o, ee_cs_oe, ee_sk_i, ee_sk_o, ee_sk_oe;
  logic ee_di_i, ee_di_o, ee_di_oe, ee_do_i;
  logic s_en, s_dual, s_mdix, s_cs;
  logic reg_wr_en;
  logic [5:0] reg_wr_addr;
  logic [15:0] reg_wr_data;
  logic [NR*16-1:0] cfg_regs;
  logic boot_done;

  logic cpu_cs, cpu_sk, cpu_di, pull_do, mdl_drv, mdl_do;
  int checks = 0, errors = 0, cyc = 0;

  assign ee_cs_i = ee_cs_oe ? ee_cs_o : cpu_cs;
  assign ee_sk_i = ee_sk_oe ? ee_sk_o : cpu_sk;
  assign ee_di_i = ee_di_oe ? ee_di_o : cpu_di;
  assign ee_do_i = mdl_drv ? mdl_do : pull_do;

  cfg_boot_loader #(
    .NUM_REGS(NR), .SK_HALF(SKH), .STRAP_DLY(SDLY), .LOAD_DLY(LDLY),
    .CPU_OK_DLY(CDLY), .SIG_VALUE(SIG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ee_cs_i(ee_cs_i), .ee_cs_o(ee_cs_o), .ee_cs_oe(ee_cs_oe),
    .ee_sk_i(ee_sk_i), .ee_sk_o(ee_sk_o), .ee_sk_oe(ee_sk_oe),
    .ee_di_i(ee_di_i), .ee_di_o(ee_di_o), .ee_di_oe(ee_di_oe),
    .ee_do_i(ee_do_i),
    .strap_eeprom_en(s_en), .strap_dual_color(s_dual),
    .strap_auto_mdix(s_mdix), .strap_cs_level(s_cs),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .cfg_regs(cfg_regs), .boot_done(boot_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // ---------------- EEPROM model ----------------
  logic [15:0] mem [0:63];
  logic [15:0] expv [0:NR-1];
  int m_cnt = 0, m_frames = 0, m_fmt_bad = 0, m_sk_bad = 0;
  logic [8:0] m_cmd;
  logic [5:0] m_addr;
  realtime t_rise;

  always @(posedge ee_cs_o) m_cnt = 0;

  always @(posedge ee_sk_o) begin
    if (ee_cs_o) begin
      t_rise = $realtime;
      if (m_cnt < 9) m_cmd = {m_cmd[7:0], ee_di_o};
      m_cnt++;
      if (m_cnt == 9) begin
        if (m_cmd[8:6] != 3'b110) m_fmt_bad++;
        m_addr = m_cmd[5:0];
        if (int'(m_addr) != m_frames) m_fmt_bad++;
        m_frames++;
      end
    end
  end

  always @(negedge ee_sk_o) begin
    if (ee_cs_o) begin
      if ($realtime - t_rise != SKH * 5.0) m_sk_bad++;
      if (m_cnt >= 9 && m_cnt < 25) begin
        mdl_drv = 1'b1;
        mdl_do  = mem[m_addr][24 - m_cnt];
      end
    end
  end

  always @(negedge ee_cs_o) begin
    if (m_cnt != 25) m_fmt_bad++;
    mdl_drv = 1'b0;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NR*16-1:0] exp_flat();
    logic [NR*16-1:0] v;
    for (int i = 0; i < NR; i++) v[i*16 +: 16] = expv[i];
    return v;
  endfunction

  function automatic logic frame_ok(input logic [63:0] f, input int n);
    return (n == 25) && f[24] && (f[23:22] == 2'b01) &&
           (f[21:16] != 6'd0) && (int'(f[21:16]) <= NR);
  endfunction

  task automatic wait_cyc(input int n);
    while (cyc < n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(input logic [63:0] f, input int n);
    @(negedge clk);
    cpu_cs = 1'b1;
    for (int b = n - 1; b >= 0; b--) begin
      cpu_di = f[b];
      idle(HHALF);
      cpu_sk = 1'b1;
      idle(HHALF);
      cpu_sk = 1'b0;
    end
    idle(HHALF);
    cpu_cs = 1'b0;
    cpu_di = 1'b0;
  endtask

  task automatic cpu_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    idle(2);
  endtask

  // boot with given straps {en, dual, mdix, cs}; checks R1 and R2
  task automatic boot(input logic [3:0] st);
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
    pull_do = st[3]; cpu_di = st[2]; cpu_sk = st[1]; cpu_cs = st[0];
    m_frames = 0; m_fmt_bad = 0; m_sk_bad = 0; m_cnt = 0; mdl_drv = 1'b0; mdl_do = 1'b0;
    for (int i = 0; i < NR; i++) expv[i] = '0;
    idle(6);
    check("R1 oe in reset", {ee_cs_oe, ee_sk_oe, ee_di_oe}, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    check("R2 strap defaults", {s_en, s_dual, s_mdix, s_cs}, 4'b1000);
    check("R1 oe early", {ee_cs_oe, ee_sk_oe, ee_di_oe}, 0);
    wait_cyc(SDLY + 10);
    check("R2 strap latched", {s_en, s_dual, s_mdix, s_cs}, st);
    cpu_di = ~st[2]; cpu_sk = ~st[1]; cpu_cs = ~st[0];
    idle(3);
    check("R2 strap held", {s_en, s_dual, s_mdix, s_cs}, st);
    cpu_di = 1'b0; cpu_sk = 1'b0; cpu_cs = 1'b0; pull_do = 1'b1;
    wait_cyc(LDLY - 6);
    check("R1 oe before load", {ee_cs_oe, ee_sk_oe, ee_di_oe}, 0);
    while (!boot_done && cyc < 20000) @(negedge clk);
    check("R3 boot_done", boot_done, 1'b1);
    check("R8 pins released", {ee_cs_oe, ee_sk_oe, ee_di_oe}, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5.0);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [63:0] f;
    int n, kind, a;
    logic [15:0] d;
    void'($urandom(32'h5eed_c0de));
    cpu_cs = 0; cpu_sk = 0; cpu_di = 0; pull_do = 1; mdl_drv = 0; mdl_do = 0;
    rst_n = 0; reg_wr_en = 0; reg_wr_addr = '0; reg_wr_data = '0;

    // Scenario 1: EEPROM strap off (R3)
    boot(4'b0110);
    check("R3 no frames", m_frames, 0);
    check("R3 regs zero", cfg_regs, '0);

    // Scenario 2: bad signature (R6)
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    mem[0] = SIG ^ 16'h0100;
    boot(4'b1000);
    check("R6 one frame", m_frames, 1);
    check("R6 regs zero", cfg_regs, '0);
    check("R4 frame format", m_fmt_bad, 0);

    // Scenario 3: good signature (R4 R5 R7), then snooping and direct writes
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    mem[0] = SIG;
    boot(4'b1101);
    check("R5 frame count", m_frames, NR + 1);
    check("R4 format/order", m_fmt_bad, 0);
    check("R4 SK half period", m_sk_bad, 0);
    for (int i = 0; i < NR; i++) expv[i] = mem[i + 1];
    check("R7 regs loaded", cfg_regs, exp_flat());

    // direct write inside the settling window is ignored (R11)
    cpu_write(6'd1, 16'hdead);
    check("R11 early write ignored", cfg_regs, exp_flat());

    // directed valid writes to each address (R9)
    for (int k = 1; k <= NR; k++) begin
      d = 16'($urandom);
      send_frame({39'd0, 1'b1, 2'b01, 6'(k), d}, 25);
      idle(8);
      expv[k - 1] = d;
      check("R9 snoop write", cfg_regs, exp_flat());
    end

    // random mix of good and bad frames (R9 R10)
    for (int t = 0; t < 14; t++) begin
      kind = $urandom_range(0, 4);
      a = $urandom_range(1, NR);
      d = 16'($urandom);
      f = '0;
      n = 25;
      case (kind)
        0: f = {39'd0, 1'b1, 2'b01, 6'(a), d};
        1: f = {39'd0, 1'b1, 2'b10, 6'(a), d};
        2: f = {39'd0, 1'b1, 2'b01, ($urandom_range(0, 1) == 0) ? 6'd0 : 6'($urandom_range(NR + 1, 63)), d};
        3: begin f = {30'd0, 1'b1, 2'b00, 6'b110000, 1'b1, 2'b01, 6'(a), d}; n = 34; end
        default: begin f = {39'd0, 1'b1, 2'b01, 6'(a), d} >> 1; n = 24; end
      endcase
      send_frame(f, n);
      idle(8);
      if (frame_ok(f, n)) expv[f[21:16] - 1] = f[15:0];
      if (kind == 0) check("R9 random write", cfg_regs, exp_flat());
      else           check("R10 ignored frame", cfg_regs, exp_flat());
    end

    // direct writes after the window (R11)
    wait_cyc(CDLY + 20);
    cpu_write(6'd2, 16'hbeef);
    expv[2] = 16'hbeef;
    check("R11 write accepted", cfg_regs, exp_flat());
    cpu_write(6'(NR), 16'h1234);
    check("R11 out of range ignored", cfg_regs, exp_flat());

    // snooped write and direct write to the same register in one cycle (R12)
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 6'd0; reg_wr_data = 16'h0f0f;
    send_frame({39'd0, 1'b1, 2'b01, 6'd1, 16'ha5a5}, 25);
    repeat (3) @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
    idle(4);
    expv[0] = 16'ha5a5;
    check("R12 snoop wins", cfg_regs, exp_flat());
    check("R8 still released", {ee_cs_oe, ee_sk_oe, ee_di_oe}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule